// File: doc/BRIEF.md
# Assertion Fire Trace Converter

This block sits between a bank of on-chip assertion checkers and a narrow debug trace field. The checkers are grouped into equal sets, and only one set's results fit into the trace word each cycle. Every clock, the block looks at the sets that need attention and picks the lowest-numbered one. It then emits that set's number together with all of its fire bits and raises a valid flag.

Any set that needs attention but loses the pick keeps its fire bits in a pending register. The bits are sent on a later cycle, so a violation is not lost just because another set fired at the same time. If new fire bits reach a set whose pending register is still occupied, the new bits are ORed into it. The block raises an overflow pulse in that case, because repeated hits can no longer be told apart.

The surrounding debug logic stores the trace word or sends it off chip. That logic and any framing are outside this block.

Top module: `chk_trace_conv`

## Requirements
- R1: While reset is high, and in the first cycle after it is released, the valid flag, the trace word and the overflow flag are all zero.
- R2: All outputs are registered. Fire bits applied before a clock edge appear on the trace word just after that edge. The set's fire bits occupy trace bits [SET_W-1:0], and the set number occupies bits [SET_W+IDX_W-1:SET_W].
- R3: Every fire bit of the chosen set is reported in the same word, so several simultaneous violations within one set stay distinguishable.
- R4: A set is eligible when its current fire bits, ORed with its pending bits, are non-zero. The lowest-numbered eligible set is chosen, so set 0 has the highest priority.
- R5: An eligible set that is not chosen keeps its bits pending. It is reported on a later cycle, with lower-numbered sets going first.
- R6: A set's new fire bits are merged by OR with its pending bits, and the merged value is what is reported.
- R7: When no set is eligible, the valid flag is low in the next cycle and the trace word is all zeros.
- R8: The overflow flag is a one-cycle pulse, aligned with the trace word. It is high after any edge at which some set had non-zero fire bits while its pending register was non-zero.
- R9: Trace bits above the set number field, [TRACE_W-1:SET_W+IDX_W], are always zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| fire_i | input | NUM_SETS*SET_W | Checker fire bits; set s occupies bits [s*SET_W +: SET_W] |
| trace_valid_o | output | 1 | Trace word carries a set report |
| trace_o | output | TRACE_W | Zero padding, then set number, then fire bits (MSB to LSB) |
| overflow_o | output | 1 | Fire bits merged into an already pending set |

## Verification
The assertions take fire_i to be a registered, reset-clean vector. A set may fire in consecutive cycles, but nothing may float, because pending state is built from the raw OR of the inputs. The priority and no-drop checks assume the trace consumer never stalls: the block emits one report each cycle and has no back-pressure. The stimulus is driven on the falling clock edge from a single task and is held at zero during reset. It includes cases that deliberately build up backlogs across several sets, and it lets them drain fully before the run ends.

// File: rtl/atc_pkg.sv
package atc_pkg;
    localparam int unsigned DEF_SETS    = 4;
    localparam int unsigned DEF_SET_W   = 4;
    localparam int unsigned DEF_TRACE_W = 8;

    // index width, never below one bit
    function automatic int unsigned idx_width(input int unsigned n);
        return (n > 1) ? $clog2(n) : 1;
    endfunction
endpackage

// File: rtl/atc_set_slot.sv
module atc_set_slot #(
    parameter int unsigned SET_W = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [SET_W-1:0] fire,
    input  logic             grant,
    output logic [SET_W-1:0] req,
    output logic [SET_W-1:0] pend,
    output logic             ovf_hit
);
    logic [SET_W-1:0] pend_q;

    assign req     = pend_q | fire;
    assign pend    = pend_q;
    assign ovf_hit = (|fire) && (|pend_q);

    always_ff @(posedge clk) begin
        if (rst)        pend_q <= '0;
        else if (grant) pend_q <= '0;
        else            pend_q <= req;
    end

    // R5: granted set always leaves its slot empty
    assert_grant_clears_R5: assert property (@(posedge clk) disable iff (rst)
        grant |=> (pend_q == '0));
endmodule

// File: rtl/atc_prio_pick.sv
module atc_prio_pick #(
    parameter int unsigned NUM_SETS = 4,
    parameter int unsigned IDX_W    = 2
) (
    input  logic [NUM_SETS-1:0] want,
    output logic [NUM_SETS-1:0] gnt,
    output logic [IDX_W-1:0]    idx,
    output logic                any
);
    always_comb begin
        gnt = '0;
        idx = '0;
        for (int i = NUM_SETS - 1; i >= 0; i--) begin
            if (want[i]) begin
                gnt    = '0;
                gnt[i] = 1'b1;
                idx    = IDX_W'(i);
            end
        end
    end
    assign any = |want;

    // R4: at most one winner, and one whenever anything is eligible
    always_comb begin
        assert_one_grant_R4: assert ($onehot0(gnt) && ((|gnt) == (|want)));
    end
endmodule

// File: rtl/atc_trace_pack.sv
module atc_trace_pack #(
    parameter int unsigned NUM_SETS = 4,
    parameter int unsigned SET_W    = 4,
    parameter int unsigned IDX_W    = 2,
    parameter int unsigned TRACE_W  = 8
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic [NUM_SETS*SET_W-1:0] req_flat,
    input  logic [IDX_W-1:0]          idx,
    input  logic                      any,
    input  logic                      ovf_in,
    output logic                      valid_o,
    output logic [TRACE_W-1:0]        trace_o,
    output logic                      ovf_o
);
    logic [SET_W-1:0]   sel_bits;
    logic [TRACE_W-1:0] word;

    always_comb begin
        sel_bits = '0;
        for (int s = 0; s < NUM_SETS; s++)
            if (idx == IDX_W'(s)) sel_bits = req_flat[s*SET_W +: SET_W];
        word = '0;
        if (any) begin
            word[SET_W-1:0]      = sel_bits;
            word[SET_W +: IDX_W] = idx;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            valid_o <= 1'b0;
            trace_o <= '0;
            ovf_o   <= 1'b0;
        end else begin
            valid_o <= any;
            trace_o <= word;
            ovf_o   <= ovf_in;
        end
    end

    assert_idle_zero_R7: assert property (@(posedge clk) disable iff (rst)
        !valid_o |-> (trace_o == '0));
    assert_bits_present_R3: assert property (@(posedge clk) disable iff (rst)
        valid_o |-> (trace_o[SET_W-1:0] != '0));
endmodule

// File: rtl/chk_trace_conv.sv
module chk_trace_conv
    import atc_pkg::*;
#(
    parameter int unsigned NUM_SETS = DEF_SETS,
    parameter int unsigned SET_W    = DEF_SET_W,
    parameter int unsigned TRACE_W  = DEF_TRACE_W
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic [NUM_SETS*SET_W-1:0] fire_i,
    output logic                      trace_valid_o,
    output logic [TRACE_W-1:0]        trace_o,
    output logic                      overflow_o
);
    localparam int unsigned IDX_W  = idx_width(NUM_SETS);
    localparam int unsigned USED_W = SET_W + IDX_W;

    logic [NUM_SETS*SET_W-1:0] req_flat, pend_flat;
    logic [NUM_SETS-1:0]       want, gnt, hit;
    logic [IDX_W-1:0]          idx;
    logic                      any;

    for (genvar s = 0; s < NUM_SETS; s++) begin : g_slot
        atc_set_slot #(.SET_W(SET_W)) u_slot (
            .clk(clk), .rst(rst),
            .fire(fire_i[s*SET_W +: SET_W]),
            .grant(gnt[s]),
            .req(req_flat[s*SET_W +: SET_W]),
            .pend(pend_flat[s*SET_W +: SET_W]),
            .ovf_hit(hit[s])
        );
        assign want[s] = |req_flat[s*SET_W +: SET_W];

        // R4: a reported set implies no lower set is left waiting
        assert_priority_R4: assert property (@(posedge clk) disable iff (rst)
            (trace_valid_o && (trace_o[SET_W +: IDX_W] > IDX_W'(s)))
                |-> (pend_flat[s*SET_W +: SET_W] == '0));
    end

    atc_prio_pick #(.NUM_SETS(NUM_SETS), .IDX_W(IDX_W)) u_pick (
        .want(want), .gnt(gnt), .idx(idx), .any(any)
    );

    atc_trace_pack #(
        .NUM_SETS(NUM_SETS), .SET_W(SET_W), .IDX_W(IDX_W), .TRACE_W(TRACE_W)
    ) u_pack (
        .clk(clk), .rst(rst),
        .req_flat(req_flat), .idx(idx), .any(any), .ovf_in(|hit),
        .valid_o(trace_valid_o), .trace_o(trace_o), .ovf_o(overflow_o)
    );

    // R5: leftover work means a report was produced at the same edge
    assert_no_drop_R5: assert property (@(posedge clk) disable iff (rst)
        (|pend_flat) |-> trace_valid_o);
    // R8: overflow only follows an edge that already had pending bits
    assert_no_overflow_R8: assert property (@(posedge clk) disable iff (rst)
        overflow_o |-> $past(|pend_flat));

    if (TRACE_W > USED_W) begin : g_pad
        assert_pad_zero_R9: assert property (@(posedge clk) disable iff (rst)
            trace_o[TRACE_W-1:USED_W] == '0);
    end
endmodule

// File: tb/sim_chk_trace_conv.sv
`timescale 1ns/1ps
module sim_chk_trace_conv;
    localparam int NS = 4;
    localparam int SW = 4;
    localparam int TW = 8;

    typedef struct {
        logic         v;
        logic [TW-1:0] t;
        logic         o;
        string        tag;
    } item_t;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic [NS*SW-1:0] fire_i = '0;
    logic trace_valid_o, overflow_o;
    logic [TW-1:0] trace_o;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;
    item_t q[$];
    logic [SW-1:0] mp [NS];

    always #2.5 clk = ~clk;

    chk_trace_conv u0 (
        .clk(clk), .rst(rst), .fire_i(fire_i),
        .trace_valid_o(trace_valid_o), .trace_o(trace_o), .overflow_o(overflow_o)
    );

    // driver: apply one cycle of fire bits, push the expected result
    task automatic step(input logic [NS*SW-1:0] f, input string tag);
        item_t it;
        logic [SW-1:0] rq [NS];
        int sel = -1;
        @(negedge clk);
        fire_i = f;
        it.o = 1'b0;
        for (int s = 0; s < NS; s++) begin
            rq[s] = mp[s] | f[s*SW +: SW];
            if (f[s*SW +: SW] != 0 && mp[s] != 0) it.o = 1'b1;
            if (sel < 0 && rq[s] != 0) sel = s;
        end
        it.v = (sel >= 0);
        it.t = '0;
        if (sel >= 0) it.t = {2'b00, 2'(sel), rq[sel]};
        for (int s = 0; s < NS; s++) mp[s] = (s == sel) ? '0 : rq[s];
        it.tag = tag;
        q.push_back(it);
    endtask

    // monitor: compare just after each rising edge
    always @(posedge clk) begin
        #1;
        if (q.size() > 0) begin
            item_t e;
            e = q.pop_front();
            checks++;
            if (trace_valid_o !== e.v || trace_o !== e.t || overflow_o !== e.o) begin
                fails++;
                $display("FAIL %s: got v=%0b t=%h o=%0b exp v=%0b t=%h o=%0b",
                         e.tag, trace_valid_o, trace_o, overflow_o, e.v, e.t, e.o);
            end
        end
    end

    initial begin
        for (int s = 0; s < NS; s++) mp[s] = '0;
        repeat (3) @(negedge clk);
        checks++;
        if (trace_valid_o !== 1'b0 || trace_o !== '0 || overflow_o !== 1'b0) begin
            fails++;
            $display("FAIL R1: got v=%0b t=%h o=%0b exp all zero", trace_valid_o, trace_o, overflow_o);
        end
        rst = 1'b0;
        step(16'h0000, "R1");
        step(16'h0000, "R7");
        step(16'h0002, "R2");
        step(16'h0040, "R2");
        step(16'h0500, "R2");
        step(16'h8000, "R2");
        step(16'h00B0, "R3");
        step(16'h0000, "R7");
        step(16'h7070, "R4");
        step(16'h0000, "R5");
        step(16'h1111, "R4");
        step(16'h0000, "R5");
        step(16'h0000, "R5");
        step(16'h0000, "R5");
        step(16'h0000, "R7");
        step(16'h0201, "R4");
        step(16'h0402, "R8");
        step(16'h0000, "R6");
        step(16'h0000, "R7");
        step(16'hF00F, "R4");
        step(16'h4001, "R8");
        step(16'h0000, "R6");
        step(16'h0000, "R9");
        step(16'hFFFF, "R9");
        step(16'hFFFF, "R8");
        step(16'h0000, "R5");
        step(16'h0000, "R5");
        step(16'h0000, "R5");
        step(16'h0000, "R7");
        @(negedge clk);
        fire_i = '0;
        repeat (3) @(negedge clk);
        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end

    initial begin
        #100000;
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: got hang exp completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
            $finish;
        end
    end
endmodule